// File: doc/BRIEF.md
# Dual-Ring Host/Controller Mailbox

This block is a mailbox between a host processor and an embedded controller. It has two independent circular buffers of 32-bit words. One carries words from the host to the controller and the other carries words from the controller to the host. Each side reaches the mailbox through its own four-register port, selected by a 2-bit word index. Index 0 is a push window that writes into the buffer this side sends on. Index 1 is this side's own control/status word. Index 2 is a pop window that reads from the buffer this side receives on. Index 3 is a read-only copy of the other side's control/status word.

Each control/status word holds three things: the pointers and the fixed depth of the buffer that side sends on, a ready/reset pair, and an interrupt enable/status/generate triple. Software works out fill level and free space by subtracting the 8-bit pointers. A queue reset is a two-sided handshake. Setting a reset bit drops both ready bits and holds both buffers empty. The controller then raises its ready bit. The host finishes with one write that clears reset, sets ready and signals the peer. A write of the generate bit signals the other side, which raises its interrupt line when that side has interrupts enabled.

Top module: `mbox_ring_top`

## Requirements
- R1: Register index 0 pushes, index 1 is the side's own control/status word, index 2 pops, and index 3 returns the other side's control/status word. Writes to index 3 change nothing. Reads of index 0 return zero.
- R2: Each control/status word is laid out as follows: bit 0 enable, bit 1 status, bit 2 generate, bit 3 ready, bit 4 reset, bits 7:5 zero, bits 15:8 read pointer, bits 23:16 write pointer, bits 31:24 depth. After reset every bit is zero except the depth field.
- R3: An accepted push stores the word and adds one to the 8-bit write pointer. A pop returns the oldest word and adds one to the read pointer. Order is kept across the pointer wrap from 255 to 0.
- R4: The fill level is the write pointer minus the read pointer, modulo 256, and never exceeds DEPTH. A push while the buffer is full is dropped and sets that buffer's overflow output. The overflow output stays set until the next queue reset.
- R5: A pop from an empty buffer returns zero and leaves both pointers unchanged.
- R6: A write with the reset bit (bit 4) set clears both sides' ready bits from the next cycle. While either reset bit is set, the pointers of both buffers are held at zero, pushes are dropped, and both overflow outputs are cleared.
- R7: A single host write with reset=0, ready=1 and generate=1 (value 0x0C) completes the reset. After it the host ready bit reads 1, the reset bit reads 0, and the controller's status bit is set.
- R8: Writing 1 to bit 2 sets the other side's status bit in the next cycle. Bit 2 always reads 0.
- R9: Writing 1 to bit 1 clears the writer's own status bit. If the peer generates in the same cycle, the status bit stays set.
- R10: Each side's interrupt output is high exactly when that side's enable and status bits are both 1.
- R11: Writes to the pointer, depth and spare fields (bits 31:5) of a control/status word are ignored. The depth field always reads DEPTH.
- R12: The controller port behaves the same way in the reverse direction: it pushes into the controller-to-host buffer and pops from the host-to-controller buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access strobe, one access per cycle |
| hostWr | input | 1 | Host access is a write when 1 |
| hostAddr | input | 2 | Host register word index |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, valid in the cycle of the access |
| hostIrq | output | 1 | Host interrupt line |
| ctlSel | input | 1 | Controller access strobe |
| ctlWr | input | 1 | Controller access is a write when 1 |
| ctlAddr | input | 2 | Controller register word index |
| ctlWdata | input | 32 | Controller write data |
| ctlRdata | output | 32 | Controller read data, valid in the cycle of the access |
| ctlIrq | output | 1 | Controller interrupt line |
| h2cOverflow | output | 1 | Sticky drop flag of the host-to-controller buffer |
| c2hOverflow | output | 1 | Sticky drop flag of the controller-to-host buffer |

## Verification
The transfer path is tested with several patterns, each aimed at a different fault:
- A short burst drained at once shows whether pointer bookkeeping and word order are right.
- A burst one word longer than the depth shows whether full detection is exact and whether the drop flag sticks.
- Several hundred push/pop pairs carry the 8-bit pointers across the wrap, which exposes wrong index truncation.
- Traffic in the reverse direction, plus pops from an empty buffer, separates the two rings and shows whether underflow moves pointers.

The interrupt tests drive status set and clear in the same cycle to confirm that set wins. The reset tests stop at each step of the handshake and check ready bits, pointers and dropped pushes at each point.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PTR_W  = 8;

  typedef enum logic [1:0] {
    REG_WIN_WR = 2'd0,
    REG_CSR    = 2'd1,
    REG_WIN_RD = 2'd2,
    REG_PEER   = 2'd3
  } regSel_e;

  // Strobes from the control block to one ring.
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } ringStrobe_t;

  // Stored handshake and interrupt bits of one side.
  typedef struct packed {
    logic ie;
    logic is;
    logic rdy;
    logic rst;
  } sideBits_t;

  function automatic logic [WORD_W-1:0] packCsr(input sideBits_t b,
                                                input logic [PTR_W-1:0] rdPtr,
                                                input logic [PTR_W-1:0] wrPtr,
                                                input logic [7:0] depth);
    return {depth, wrPtr, rdPtr, 3'b000, b.rst, b.rdy, 1'b0, b.is, b.ie};
  endfunction
endpackage

// File: rtl/mbox_ring.sv
module mbox_ring
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ringStrobe_t         stb,
  input  logic [WORD_W-1:0]   pushData,
  output logic [PTR_W-1:0]    rdPtr,
  output logic [PTR_W-1:0]    wrPtr,
  output logic [WORD_W-1:0]   headData,
  output logic                overflow
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic [WORD_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  fill;
  logic              isFull;
  logic              isEmpty;
  logic              doPush;
  logic              doPop;

  assign fill    = wrPtr - rdPtr;
  assign isFull  = (fill >= DEPTH_P);
  assign isEmpty = (fill == '0);
  assign doPush  = stb.push && !stb.clear && !isFull;
  assign doPop   = stb.pop && !stb.clear && !isEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      overflow <= 1'b0;
    end else if (stb.clear) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      else if (stb.push) overflow <= 1'b1;
      if (doPop) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr[IDX_W-1:0]] <= pushData;
  end

  assign headData = isEmpty ? '0 : store[rdPtr[IDX_W-1:0]];
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [4:0]        hostWbits,
  input  logic              ctlSel,
  input  logic              ctlWr,
  input  logic [1:0]        ctlAddr,
  input  logic [4:0]        ctlWbits,
  input  logic [PTR_W-1:0]  h2cRdPtr,
  input  logic [PTR_W-1:0]  h2cWrPtr,
  input  logic [PTR_W-1:0]  c2hRdPtr,
  input  logic [PTR_W-1:0]  c2hWrPtr,
  input  logic [WORD_W-1:0] h2cHead,
  input  logic [WORD_W-1:0] c2hHead,
  output ringStrobe_t       h2cStb,
  output ringStrobe_t       c2hStb,
  output logic [WORD_W-1:0] hostRdata,
  output logic [WORD_W-1:0] ctlRdata,
  output logic [WORD_W-1:0] hostCsr,
  output logic [WORD_W-1:0] ctlCsr,
  output logic              hostIrq,
  output logic              ctlIrq
);
  localparam logic [7:0] DEPTH_F = 8'(DEPTH);
  localparam int unsigned SIDES = 2;

  // Index 0 is the host side, index 1 the controller side.
  logic      csrWr   [SIDES];
  logic      igPulse [SIDES];
  logic [4:0] wBits  [SIDES];
  sideBits_t sideQ   [SIDES];
  logic      anyRst;

  always_comb begin
    csrWr[0] = hostSel && hostWr && (regSel_e'(hostAddr) == REG_CSR);
    csrWr[1] = ctlSel && ctlWr && (regSel_e'(ctlAddr) == REG_CSR);
    wBits[0] = hostWbits;
    wBits[1] = ctlWbits;
    for (int s = 0; s < SIDES; s++) igPulse[s] = csrWr[s] && wBits[s][2];
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int PEER = 1 - s;
    sideBits_t nxt;
    always_comb begin
      nxt = sideQ[s];
      if (csrWr[s]) begin
        nxt.ie  = wBits[s][0];
        nxt.rst = wBits[s][4];
        nxt.rdy = wBits[s][3] && !wBits[s][4];
        if (wBits[s][1]) nxt.is = 1'b0;
      end
      if (csrWr[PEER] && wBits[PEER][4]) nxt.rdy = 1'b0;
      if (igPulse[PEER]) nxt.is = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (!rstN) sideQ[s] <= '0;
      else       sideQ[s] <= nxt;
    end
  end

  assign anyRst = sideQ[0].rst || sideQ[1].rst;

  always_comb begin
    h2cStb.push  = hostSel && hostWr && (regSel_e'(hostAddr) == REG_WIN_WR);
    h2cStb.pop   = ctlSel && !ctlWr && (regSel_e'(ctlAddr) == REG_WIN_RD);
    h2cStb.clear = anyRst;
    c2hStb.push  = ctlSel && ctlWr && (regSel_e'(ctlAddr) == REG_WIN_WR);
    c2hStb.pop   = hostSel && !hostWr && (regSel_e'(hostAddr) == REG_WIN_RD);
    c2hStb.clear = anyRst;
  end

  assign hostCsr = packCsr(sideQ[0], h2cRdPtr, h2cWrPtr, DEPTH_F);
  assign ctlCsr  = packCsr(sideQ[1], c2hRdPtr, c2hWrPtr, DEPTH_F);
  assign hostIrq = sideQ[0].ie && sideQ[0].is;
  assign ctlIrq  = sideQ[1].ie && sideQ[1].is;

  always_comb begin
    hostRdata = '0;
    if (hostSel && !hostWr) begin
      unique case (regSel_e'(hostAddr))
        REG_CSR:    hostRdata = hostCsr;
        REG_WIN_RD: hostRdata = c2hHead;
        REG_PEER:   hostRdata = ctlCsr;
        default:    hostRdata = '0;
      endcase
    end
  end

  always_comb begin
    ctlRdata = '0;
    if (ctlSel && !ctlWr) begin
      unique case (regSel_e'(ctlAddr))
        REG_CSR:    ctlRdata = ctlCsr;
        REG_WIN_RD: ctlRdata = h2cHead;
        REG_PEER:   ctlRdata = hostCsr;
        default:    ctlRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbox_ring_top.sv
module mbox_ring_top
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostSel,
  input  logic        hostWr,
  input  logic [1:0]  hostAddr,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        hostIrq,
  input  logic        ctlSel,
  input  logic        ctlWr,
  input  logic [1:0]  ctlAddr,
  input  logic [31:0] ctlWdata,
  output logic [31:0] ctlRdata,
  output logic        ctlIrq,
  output logic        h2cOverflow,
  output logic        c2hOverflow
);
  ringStrobe_t       h2cStb, c2hStb;
  logic [PTR_W-1:0]  h2cRdPtr, h2cWrPtr, c2hRdPtr, c2hWrPtr;
  logic [WORD_W-1:0] h2cHead, c2hHead;
  logic [WORD_W-1:0] hostCsr, ctlCsr;

  mbox_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr), .hostWbits(hostWdata[4:0]),
    .ctlSel(ctlSel), .ctlWr(ctlWr), .ctlAddr(ctlAddr), .ctlWbits(ctlWdata[4:0]),
    .h2cRdPtr(h2cRdPtr), .h2cWrPtr(h2cWrPtr), .c2hRdPtr(c2hRdPtr), .c2hWrPtr(c2hWrPtr),
    .h2cHead(h2cHead), .c2hHead(c2hHead),
    .h2cStb(h2cStb), .c2hStb(c2hStb),
    .hostRdata(hostRdata), .ctlRdata(ctlRdata),
    .hostCsr(hostCsr), .ctlCsr(ctlCsr),
    .hostIrq(hostIrq), .ctlIrq(ctlIrq)
  );

  mbox_ring #(.DEPTH(DEPTH)) h2cRing_i (
    .clk(clk), .rstN(rstN), .stb(h2cStb), .pushData(hostWdata),
    .rdPtr(h2cRdPtr), .wrPtr(h2cWrPtr), .headData(h2cHead), .overflow(h2cOverflow)
  );

  mbox_ring #(.DEPTH(DEPTH)) c2hRing_i (
    .clk(clk), .rstN(rstN), .stb(c2hStb), .pushData(ctlWdata),
    .rdPtr(c2hRdPtr), .wrPtr(c2hWrPtr), .headData(c2hHead), .overflow(c2hOverflow)
  );
endmodule

// File: rtl/mbox_ring_chk.sv
module mbox_ring_chk #(
  parameter int unsigned DEPTH = 32
) (
  input logic        clk,
  input logic        rstN,
  input logic        hostSel,
  input logic        hostWr,
  input logic [1:0]  hostAddr,
  input logic [31:0] hostWdata,
  input logic        ctlSel,
  input logic        ctlWr,
  input logic [1:0]  ctlAddr,
  input logic [31:0] ctlWdata,
  input logic [31:0] hostCsr,
  input logic [31:0] ctlCsr,
  input logic        h2cOverflow
);
  logic [7:0] h2cFill, c2hFill;
  logic       anyRst, hostPush, ctlPop, hostCsrWr, ctlCsrWr;

  assign h2cFill   = hostCsr[23:16] - hostCsr[15:8];
  assign c2hFill   = ctlCsr[23:16] - ctlCsr[15:8];
  assign anyRst    = hostCsr[4] || ctlCsr[4];
  assign hostPush  = hostSel && hostWr && hostAddr == 2'd0;
  assign ctlPop    = ctlSel && !ctlWr && ctlAddr == 2'd2;
  assign hostCsrWr = hostSel && hostWr && hostAddr == 2'd1;
  assign ctlCsrWr  = ctlSel && ctlWr && ctlAddr == 2'd1;

  assert_fill_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    (h2cFill <= 8'(DEPTH)) && (c2hFill <= 8'(DEPTH)));

  assert_full_push_dropped_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostPush && h2cFill == 8'(DEPTH) && !anyRst) |=> ($stable(hostCsr[23:16]) && h2cOverflow));

  assert_empty_pop_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctlPop && h2cFill == 8'd0 && !anyRst && !hostPush) |=> $stable(hostCsr[23:8]));

  assert_rst_clears_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostCsrWr && hostWdata[4]) |=> (!hostCsr[3] && !ctlCsr[3]));

  assert_rst_holds_ptrs_R6: assert property (@(posedge clk) disable iff (!rstN)
    anyRst |=> (hostCsr[23:8] == 16'd0 && ctlCsr[23:8] == 16'd0));

  assert_ctl_gen_sets_host_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctlCsrWr && ctlWdata[2]) |=> hostCsr[1]);

  assert_host_gen_sets_ctl_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostCsrWr && hostWdata[2]) |=> ctlCsr[1]);
endmodule

bind mbox_ring_top mbox_ring_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN),
  .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr), .hostWdata(hostWdata),
  .ctlSel(ctlSel), .ctlWr(ctlWr), .ctlAddr(ctlAddr), .ctlWdata(ctlWdata),
  .hostCsr(hostCsr), .ctlCsr(ctlCsr), .h2cOverflow(h2cOverflow)
);

// File: tb/mbox_ring_top_tb_top.sv
module mbox_ring_top_tb_top;
  localparam int unsigned TDEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWr = 1'b0;
  logic [1:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostIrq;
  logic        ctlSel = 1'b0, ctlWr = 1'b0;
  logic [1:0]  ctlAddr = '0;
  logic [31:0] ctlWdata = '0;
  logic [31:0] ctlRdata;
  logic        ctlIrq;
  logic        h2cOverflow, c2hOverflow;

  int checks = 0;
  int failures = 0;
  logic [31:0] h2cExp[$];
  logic [31:0] c2hExp[$];
  logic [31:0] rd;

  always #4 clk = ~clk;

  mbox_ring_top #(.DEPTH(TDEPTH)) dut_i (
    .clk(clk), .rstN(rstN),
    .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostIrq(hostIrq),
    .ctlSel(ctlSel), .ctlWr(ctlWr), .ctlAddr(ctlAddr), .ctlWdata(ctlWdata),
    .ctlRdata(ctlRdata), .ctlIrq(ctlIrq),
    .h2cOverflow(h2cOverflow), .c2hOverflow(c2hOverflow)
  );

  function automatic logic [31:0] mk(input int wp, input int rp, input bit rst,
                                     input bit rdy, input bit is, input bit ie);
    return {8'(TDEPTH), 8'(wp), 8'(rp), 3'b000, rst, rdy, 1'b0, is, ie};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic hostAcc(input logic wr, input logic [1:0] a, input logic [31:0] d,
                         output logic [31:0] q);
    @(negedge clk);
    hostSel = 1'b1; hostWr = wr; hostAddr = a; hostWdata = d;
    #2 q = hostRdata;
    @(posedge clk); #1;
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic ctlAcc(input logic wr, input logic [1:0] a, input logic [31:0] d,
                        output logic [31:0] q);
    @(negedge clk);
    ctlSel = 1'b1; ctlWr = wr; ctlAddr = a; ctlWdata = d;
    #2 q = ctlRdata;
    @(posedge clk); #1;
    ctlSel = 1'b0; ctlWr = 1'b0;
  endtask

  // Scoreboard driver: push and record what the design must accept.
  task automatic hostPush(input logic [31:0] d);
    logic [31:0] q;
    if (h2cExp.size() < TDEPTH) h2cExp.push_back(d);
    hostAcc(1'b1, 2'd0, d, q);
  endtask

  task automatic ctlPush(input logic [31:0] d);
    logic [31:0] q;
    if (c2hExp.size() < TDEPTH) c2hExp.push_back(d);
    ctlAcc(1'b1, 2'd0, d, q);
  endtask

  // Scoreboard monitor: pop and compare with the oldest recorded word.
  task automatic ctlPopCheck(input string req);
    logic [31:0] q;
    logic [31:0] e;
    e = (h2cExp.size() > 0) ? h2cExp.pop_front() : 32'd0;
    ctlAcc(1'b0, 2'd2, 32'd0, q);
    check(q, e, req);
  endtask

  task automatic hostPopCheck(input string req);
    logic [31:0] q;
    logic [31:0] e;
    e = (c2hExp.size() > 0) ? c2hExp.pop_front() : 32'd0;
    hostAcc(1'b0, 2'd2, 32'd0, q);
    check(q, e, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R2: reset state
    hostAcc(1'b0, 2'd1, 0, rd); check(rd, mk(0,0,0,0,0,0), "R2 host csr after reset");
    ctlAcc(1'b0, 2'd1, 0, rd);  check(rd, mk(0,0,0,0,0,0), "R2 ctl csr after reset");
    check({30'd0, hostIrq, ctlIrq}, 32'd0, "R10 irqs low after reset");
    check({30'd0, h2cOverflow, c2hOverflow}, 32'd0, "R4 overflow low after reset");

    // Bring both sides ready
    ctlAcc(1'b1, 2'd1, 32'h8, rd);
    hostAcc(1'b1, 2'd1, 32'h8, rd);
    hostAcc(1'b0, 2'd3, 0, rd); check(rd, mk(0,0,0,1,0,0), "R1 peer mirror");
    hostAcc(1'b0, 2'd0, 0, rd); check(rd, 32'd0, "R1 push window reads zero");

    // R3: short burst
    hostPush(32'hA1); hostPush(32'hB2); hostPush(32'hC3);
    hostAcc(1'b0, 2'd1, 0, rd); check(rd, mk(3,0,0,1,0,0), "R3 write pointer advance");
    for (int i = 0; i < 3; i++) ctlPopCheck("R3 R12 burst order");
    hostAcc(1'b0, 2'd1, 0, rd); check(rd, mk(3,3,0,1,0,0), "R3 read pointer advance");

    // R5: pop empty
    ctlPopCheck("R5 empty pop data");
    hostAcc(1'b0, 2'd1, 0, rd); check(rd, mk(3,3,0,1,0,0), "R5 pointers unchanged");

    // R4: overfill by one
    for (int i = 0; i < TDEPTH + 1; i++) hostPush(32'h100 + i);
    hostAcc(1'b0, 2'd1, 0, rd); check(rd, mk(11,3,0,1,0,0), "R4 dropped push");
    check({31'd0, h2cOverflow}, 32'd1, "R4 overflow set");
    for (int i = 0; i < TDEPTH + 1; i++) ctlPopCheck("R4 drain after full");

    // R3: pointer wrap
    for (int i = 0; i < 250; i++) begin
      hostPush(32'h5000 + i);
      ctlPopCheck("R3 wrap order");
    end
    hostAcc(1'b0, 2'd1, 0, rd); check(rd, mk(5,5,0,1,0,0), "R3 pointer wrap");
    check({31'd0, h2cOverflow}, 32'd1, "R4 overflow sticky");

    // R12: reverse direction
    ctlPush(32'hDEAD0001); ctlPush(32'hDEAD0002);
    hostAcc(1'b0, 2'd3, 0, rd); check(rd, mk(2,0,0,1,0,0), "R12 ctl pointers");
    hostPopCheck("R12 reverse data"); hostPopCheck("R12 reverse data");
    hostAcc(1'b1, 2'd3, 32'hFFFFFFFF, rd);
    ctlAcc(1'b0, 2'd1, 0, rd); check(rd, mk(2,2,0,1,0,0), "R1 peer write ignored");

    // Interrupts
    hostAcc(1'b1, 2'd1, 32'h9, rd);
    check({31'd0, hostIrq}, 32'd0, "R10 enable without status");
    ctlAcc(1'b1, 2'd1, 32'hC, rd);
    check({31'd0, hostIrq}, 32'd1, "R10 R8 irq after peer generate");
    hostAcc(1'b0, 2'd1, 0, rd); check(rd, mk(5,5,0,1,1,1), "R8 status set");
    ctlAcc(1'b0, 2'd1, 0, rd);  check(rd, mk(2,2,0,1,0,0), "R8 generate reads zero");
    hostAcc(1'b1, 2'd1, 32'hB, rd);
    hostAcc(1'b0, 2'd1, 0, rd); check(rd, mk(5,5,0,1,0,1), "R9 write one clears");
    check({31'd0, hostIrq}, 32'd0, "R10 irq low after clear");
    @(negedge clk);
    hostSel = 1; hostWr = 1; hostAddr = 2'd1; hostWdata = 32'hB;
    ctlSel = 1; ctlWr = 1; ctlAddr = 2'd1; ctlWdata = 32'hC;
    @(posedge clk); #1;
    hostSel = 0; hostWr = 0; ctlSel = 0; ctlWr = 0;
    hostAcc(1'b0, 2'd1, 0, rd); check(rd, mk(5,5,0,1,1,1), "R9 set wins over clear");

    // R11: ignored fields
    hostAcc(1'b1, 2'd1, 32'hFFFFFFE8, rd);
    hostAcc(1'b0, 2'd1, 0, rd); check(rd, mk(5,5,0,1,1,0), "R11 upper fields ignored");
    check({31'd0, hostIrq}, 32'd0, "R10 disabled irq");

    // Controller interrupt line
    hostAcc(1'b1, 2'd1, 32'hC, rd);
    ctlAcc(1'b0, 2'd1, 0, rd); check(rd, mk(2,2,0,1,1,0), "R8 host generate sets ctl status");
    check({31'd0, ctlIrq}, 32'd0, "R10 ctl irq masked");
    ctlAcc(1'b1, 2'd1, 32'hB, rd);
    check({31'd0, ctlIrq}, 32'd0, "R9 ctl status cleared");
    hostAcc(1'b1, 2'd1, 32'hC, rd);
    check({31'd0, ctlIrq}, 32'd1, "R10 ctl irq raised");

    // R6 / R7: reset handshake
    hostPush(32'h77); hostPush(32'h78);
    hostAcc(1'b1, 2'd1, 32'h14, rd);
    h2cExp.delete(); c2hExp.delete();
    hostAcc(1'b0, 2'd1, 0, rd); check(rd & 32'h18, 32'h10, "R6 host ready dropped");
    hostAcc(1'b0, 2'd3, 0, rd); check(rd & 32'h08, 32'h0, "R6 ctl ready dropped");
    hostAcc(1'b0, 2'd1, 0, rd); check(rd & 32'h00FFFF00, 32'h0, "R6 h2c pointers held zero");
    hostAcc(1'b0, 2'd3, 0, rd); check(rd, mk(0,0,0,0,1,1), "R6 c2h pointers held zero");
    check({30'd0, h2cOverflow, c2hOverflow}, 32'd0, "R6 overflow cleared");
    ctlAcc(1'b1, 2'd0, 32'h55, rd);
    hostAcc(1'b0, 2'd3, 0, rd); check(rd & 32'h00FFFF00, 32'h0, "R6 push dropped in reset");
    ctlAcc(1'b1, 2'd1, 32'h9, rd);
    hostAcc(1'b1, 2'd1, 32'hC, rd);
    hostAcc(1'b0, 2'd1, 0, rd); check(rd, mk(0,0,0,1,1,0), "R7 reset completed");
    check({31'd0, ctlIrq}, 32'd1, "R7 ctl signalled");
    hostPush(32'hCAFE);
    ctlPopCheck("R7 traffic after reset");
    hostAcc(1'b0, 2'd1, 0, rd); check(rd, mk(1,1,0,1,1,0), "R3 pointers after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule